// File: doc/BRIEF.md
# Burst Splitter with Write Forwarding

This block sits at the front of a memory request queue. A requester presents one request at a time, made of a byte address, a length and a read or write flag. The block cuts the request into pieces that never straddle a burst boundary and handles one piece per clock. A read piece that lies wholly inside a write that is still pending is answered from that write and takes no read queue slot. A write piece that lands in a burst already held by a pending write is folded into that entry instead of taking a new one.

Admission is all-or-nothing. Before any piece is issued, the block counts the pieces the request needs and compares that count plus the current occupancy of the target queue against its depth. A request that does not fit is refused with a retry strobe. If the request could ever fit, the block then waits and raises a one-cycle room-ready pulse as soon as enough entries have been freed. The queues themselves drain through external pop strobes: read entries leave in any order, and write entries leave oldest first.

The controller has four states: IDLE, SPLIT, HOLD and FINISH. Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| ACCEPT | IDLE | SPLIT | a request is presented and it fits |
| REFUSE | IDLE | HOLD | a request is presented, it does not fit now, but it could fit in an empty queue |
| LAST | SPLIT | FINISH | the final piece has been handled |
| DONE | FINISH | IDLE | always, after one cycle |
| ROOM | HOLD | IDLE | the refused request now fits |

Top module: `burst_splitter`

## Requirements
- R1: Each piece has a size equal to the smaller of two values: the bytes from its start up to the next multiple of BURST_BYTES, and the bytes still left in the request. As a result, `push_size` lies between 1 and BURST_BYTES and no piece crosses a burst boundary.
- R2: The first piece starts at `req_addr`. Each later piece starts at the previous start OR (BURST_BYTES-1), plus one. Pieces are presented on `push_addr` and `push_size`, one per clock, in the cycles right after acceptance.
- R3: A read piece raises `fwd_hit` and no `rd_push` exactly when some pending write entry starts at or below the piece start and ends at or beyond the piece end (start + size). Otherwise the piece raises `rd_push`, and the read queue occupancy rises by one.
- R4: `fwd_count` holds the number of forwarded pieces in the current or last request. With `req_done`, `done_all_fwd` is 1 only for a read whose pieces were all forwarded.
- R5: A write piece whose address with the low log2(BURST_BYTES) bits dropped equals that of a pending write entry raises `wr_merge` and no `wr_push`, and no new write entry is taken. Otherwise the piece raises `wr_push` and takes a new entry, which is visible to lookups from the next cycle.
- R6: The piece count is ((addr+len-1) >> log2(BURST_BYTES)) - (addr >> log2(BURST_BYTES)) + 1. In IDLE, with `req_valid` high, `req_accept` is raised in the same cycle when occupancy + count <= depth of the target queue (RD_DEPTH for reads, WR_DEPTH for writes). Otherwise `req_retry` is raised and no piece is issued. The check holds even for writes that would merge.
- R7: The length is presented as `req_len_m1`, which is the length minus one, so every request has at least one piece. `req_done` pulses for one cycle in the cycle right after the last piece.
- R8: After a refusal whose count does not exceed the depth, the block holds and ignores `req_valid`. It raises `room_ready` for exactly one cycle when occupancy + count <= depth, and then returns to IDLE.
- R9: A request whose count exceeds the target queue depth is refused, leaves the block in IDLE, and never produces `room_ready`.
- R10: `wr_pop` removes the oldest pending write entry, after which no read is forwarded from it. `rd_pop` frees one read entry, and has no effect when the read queue is empty.
- R11: After reset all strobes are 0, `fwd_count` is 0, both queues are empty and the block is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request presented (sampled in IDLE) |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Byte start address |
| req_len_m1 | input | LEN_W | Request length in bytes minus one |
| req_accept | output | 1 | Request taken this cycle |
| req_retry | output | 1 | Request refused this cycle |
| room_ready | output | 1 | One-cycle pulse: a held refused request now fits |
| rd_pop | input | 1 | Free one read queue entry |
| wr_pop | input | 1 | Free the oldest write queue entry |
| rd_push | output | 1 | Read piece enters the read queue |
| wr_push | output | 1 | Write piece takes a new write entry |
| wr_merge | output | 1 | Write piece folded into an existing entry |
| fwd_hit | output | 1 | Read piece answered from a pending write |
| push_addr | output | ADDR_W | Start address of the current piece |
| push_size | output | clog2(BURST_BYTES+1) | Byte size of the current piece |
| fwd_count | output | CNT_W | Forwarded pieces in the current or last request |
| req_done | output | 1 | One-cycle pulse: all pieces handled |
| done_all_fwd | output | 1 | With req_done: every read piece was forwarded |

## Verification
The splitting arithmetic is swept over every start offset in two bursts and every length from 1 to 48 for reads, and from 1 to 32 for writes. This separates aligned from unaligned starts, pieces cut by a boundary from pieces cut by the remaining length, and counts that fit from counts that exceed a queue's depth. The directed read patterns put the pending write fully inside, partly overlapping, exactly matching and then popped away from the read piece, which tells containment apart from mere overlap. The write patterns are chosen so that merge and allocate, a fit from a refusal, and an early room signal from a correct one can each be seen apart.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SPLIT,
        ST_HOLD,
        ST_FINISH
    } bsw_state_e;

endpackage

// File: rtl/bsw_piece_calc.sv
module bsw_piece_calc #(
    parameter int ADDR_W      = 12,
    parameter int REM_W       = 7,
    parameter int BURST_BYTES = 8,
    localparam int SZ_W       = $clog2(BURST_BYTES + 1)
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [REM_W-1:0]  rem_bytes,
    output logic [SZ_W-1:0]   piece_size,
    output logic [ADDR_W-1:0] next_addr
);

    localparam int LOG2B = $clog2(BURST_BYTES);
    localparam int CW    = ((REM_W > SZ_W) ? REM_W : SZ_W) + 1;

    logic [SZ_W-1:0] to_edge;

    // Bytes from the piece start up to the next burst boundary.
    assign to_edge    = SZ_W'(BURST_BYTES) - SZ_W'(cur_addr[LOG2B-1:0]);
    assign piece_size = (CW'(rem_bytes) < CW'(to_edge)) ? SZ_W'(rem_bytes) : to_edge;
    assign next_addr  = cur_addr + ADDR_W'(to_edge);

endmodule

// File: rtl/bsw_occ_cnt.sv
module bsw_occ_cnt #(
    parameter int DEPTH = 6,
    localparam int OW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [OW-1:0] occ
);

    logic dec_ok;

    assign dec_ok = dec && (occ != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ <= '0;
        end else if (inc && !dec_ok) begin
            occ <= occ + OW'(1);
        end else if (!inc && dec_ok) begin
            occ <= occ - OW'(1);
        end
    end

endmodule

// File: rtl/bsw_wr_tags.sv
module bsw_wr_tags #(
    parameter int ADDR_W      = 12,
    parameter int BURST_BYTES = 8,
    parameter int DEPTH       = 4,
    localparam int SZ_W       = $clog2(BURST_BYTES + 1),
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [SZ_W-1:0]   alloc_size,
    input  logic              pop,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [SZ_W-1:0]   q_size,
    output logic              cover_hit,
    output logic              burst_hit,
    output logic [CW-1:0]     count
);

    localparam int LOG2B = $clog2(BURST_BYTES);
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int AW1   = ADDR_W + 1;

    logic [ADDR_W-1:0] ent_a [DEPTH];
    logic [SZ_W-1:0]   ent_s [DEPTH];
    logic [DEPTH-1:0]  ent_v;
    logic [PW-1:0]     head;
    logic [PW-1:0]     tail;
    logic [DEPTH-1:0]  cov;
    logic [DEPTH-1:0]  bm;
    logic              pop_ok;

    assign pop_ok = pop && (count != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_a[i] <= '0;
                ent_s[i] <= '0;
            end
            ent_v <= '0;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (pop_ok) begin
                ent_v[head] <= 1'b0;
                head        <= (head == PW'(DEPTH - 1)) ? '0 : head + PW'(1);
            end
            if (alloc) begin
                ent_a[tail] <= alloc_addr;
                ent_s[tail] <= alloc_size;
                ent_v[tail] <= 1'b1;
                tail        <= (tail == PW'(DEPTH - 1)) ? '0 : tail + PW'(1);
            end
            if (alloc && !pop_ok) begin
                count <= count + CW'(1);
            end else if (!alloc && pop_ok) begin
                count <= count - CW'(1);
            end
        end
    end

    // One comparator pair per entry: full containment and same burst.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign cov[g] = ent_v[g]
                     && ({1'b0, ent_a[g]} <= {1'b0, q_addr})
                     && (({1'b0, q_addr} + AW1'(q_size)) <= ({1'b0, ent_a[g]} + AW1'(ent_s[g])));
        assign bm[g]  = ent_v[g] && (ent_a[g][ADDR_W-1:LOG2B] == q_addr[ADDR_W-1:LOG2B]);
    end

    assign cover_hit = |cov;
    assign burst_hit = |bm;

endmodule

// File: rtl/burst_splitter.sv
module burst_splitter #(
    parameter int ADDR_W      = 12,
    parameter int LEN_W       = 6,
    parameter int BURST_BYTES = 8,
    parameter int RD_DEPTH    = 6,
    parameter int WR_DEPTH    = 4,
    localparam int SZ_W       = $clog2(BURST_BYTES + 1),
    localparam int MAX_PIECES = ((1 << LEN_W) + BURST_BYTES - 2) / BURST_BYTES + 1,
    localparam int CNT_W      = $clog2(MAX_PIECES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_m1,
    output logic              req_accept,
    output logic              req_retry,
    output logic              room_ready,
    input  logic              rd_pop,
    input  logic              wr_pop,
    output logic              rd_push,
    output logic              wr_push,
    output logic              wr_merge,
    output logic              fwd_hit,
    output logic [ADDR_W-1:0] push_addr,
    output logic [SZ_W-1:0]   push_size,
    output logic [CNT_W-1:0]  fwd_count,
    output logic              req_done,
    output logic              done_all_fwd
);

    import bsw_pkg::*;

    localparam int LOG2B = $clog2(BURST_BYTES);
    localparam int REM_W = LEN_W + 1;
    localparam int RO_W  = $clog2(RD_DEPTH + 1);
    localparam int WO_W  = $clog2(WR_DEPTH + 1);
    localparam int BA_W  = ADDR_W + 1 - LOG2B;

    bsw_state_e st_q, st_d;

    logic [ADDR_W-1:0] cur_q;
    logic [REM_W-1:0]  rem_q;
    logic [CNT_W-1:0]  total_q;
    logic [CNT_W-1:0]  served_q;
    logic [CNT_W-1:0]  fwd_q;
    logic              is_wr_q;
    logic              hold_wr_q;
    logic [CNT_W-1:0]  hold_need_q;

    logic [ADDR_W:0]   end_addr;
    logic [BA_W-1:0]   span;
    logic [CNT_W-1:0]  need_now;
    logic              fits_now;
    logic              too_big_now;
    logic              fits_hold;
    logic [SZ_W-1:0]   piece_size;
    logic [ADDR_W-1:0] next_addr;
    logic              cover_hit;
    logic              burst_hit;
    logic [RO_W-1:0]   rd_occ;
    logic [WO_W-1:0]   wr_cnt;
    logic              in_split;
    logic              in_last;

    // Number of bursts touched by the presented request.
    assign end_addr = {1'b0, req_addr} + {1'b0, ADDR_W'(req_len_m1)};
    assign span     = end_addr[ADDR_W:LOG2B] - {1'b0, req_addr[ADDR_W-1:LOG2B]};
    assign need_now = CNT_W'(span) + CNT_W'(1);

    assign fits_now    = req_write ? (int'(wr_cnt) + int'(need_now) <= WR_DEPTH)
                                   : (int'(rd_occ) + int'(need_now) <= RD_DEPTH);
    assign too_big_now = req_write ? (int'(need_now) > WR_DEPTH)
                                   : (int'(need_now) > RD_DEPTH);
    assign fits_hold   = hold_wr_q ? (int'(wr_cnt) + int'(hold_need_q) <= WR_DEPTH)
                                   : (int'(rd_occ) + int'(hold_need_q) <= RD_DEPTH);

    assign in_split = (st_q == ST_SPLIT);
    assign in_last  = ((served_q + CNT_W'(1)) == total_q);

    bsw_piece_calc #(
        .ADDR_W     (ADDR_W),
        .REM_W      (REM_W),
        .BURST_BYTES(BURST_BYTES)
    ) piece_i (
        .cur_addr  (cur_q),
        .rem_bytes (rem_q),
        .piece_size(piece_size),
        .next_addr (next_addr)
    );

    bsw_wr_tags #(
        .ADDR_W     (ADDR_W),
        .BURST_BYTES(BURST_BYTES),
        .DEPTH      (WR_DEPTH)
    ) tags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (wr_push),
        .alloc_addr(cur_q),
        .alloc_size(piece_size),
        .pop       (wr_pop),
        .q_addr    (cur_q),
        .q_size    (piece_size),
        .cover_hit (cover_hit),
        .burst_hit (burst_hit),
        .count     (wr_cnt)
    );

    bsw_occ_cnt #(
        .DEPTH(RD_DEPTH)
    ) rdocc_i (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (rd_push),
        .dec  (rd_pop),
        .occ  (rd_occ)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions: ACCEPT, REFUSE, LAST, DONE, ROOM.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid && fits_now) begin
                    st_d = ST_SPLIT;
                end else if (req_valid && !too_big_now) begin
                    st_d = ST_HOLD;
                end
            end
            ST_SPLIT: begin
                if (in_last) begin
                    st_d = ST_FINISH;
                end
            end
            ST_FINISH: st_d = ST_IDLE;
            ST_HOLD: begin
                if (fits_hold) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        req_accept   = 1'b0;
        req_retry    = 1'b0;
        room_ready   = 1'b0;
        rd_push      = 1'b0;
        wr_push      = 1'b0;
        wr_merge     = 1'b0;
        fwd_hit      = 1'b0;
        push_addr    = '0;
        push_size    = '0;
        req_done     = 1'b0;
        done_all_fwd = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                req_accept = req_valid && fits_now;
                req_retry  = req_valid && !fits_now;
            end
            ST_SPLIT: begin
                push_addr = cur_q;
                push_size = piece_size;
                if (is_wr_q) begin
                    wr_merge = burst_hit;
                    wr_push  = !burst_hit;
                end else begin
                    fwd_hit  = cover_hit;
                    rd_push  = !cover_hit;
                end
            end
            ST_HOLD: room_ready = fits_hold;
            ST_FINISH: begin
                req_done     = 1'b1;
                done_all_fwd = !is_wr_q && (fwd_q == total_q);
            end
            default: ;
        endcase
    end

    assign fwd_count = fwd_q;

    // Per-request bookkeeping for the piece walk.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            rem_q       <= '0;
            total_q     <= '0;
            served_q    <= '0;
            fwd_q       <= '0;
            is_wr_q     <= 1'b0;
            hold_wr_q   <= 1'b0;
            hold_need_q <= '0;
        end else begin
            if (st_q == ST_IDLE && req_valid) begin
                if (fits_now) begin
                    cur_q    <= req_addr;
                    rem_q    <= REM_W'(req_len_m1) + REM_W'(1);
                    total_q  <= need_now;
                    served_q <= '0;
                    fwd_q    <= '0;
                    is_wr_q  <= req_write;
                end else begin
                    hold_wr_q   <= req_write;
                    hold_need_q <= need_now;
                end
            end
            if (in_split) begin
                cur_q    <= next_addr;
                rem_q    <= rem_q - REM_W'(piece_size);
                served_q <= served_q + CNT_W'(1);
                if (fwd_hit) begin
                    fwd_q <= fwd_q + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/burst_splitter_chk.sv
module burst_splitter_chk #(
    parameter int ADDR_W      = 12,
    parameter int BURST_BYTES = 8,
    parameter int RD_DEPTH    = 6,
    parameter int WR_DEPTH    = 4,
    localparam int SZ_W       = $clog2(BURST_BYTES + 1),
    localparam int RO_W       = $clog2(RD_DEPTH + 1),
    localparam int WO_W       = $clog2(WR_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_push,
    input logic              wr_push,
    input logic              fwd_hit,
    input logic              wr_merge,
    input logic [ADDR_W-1:0] push_addr,
    input logic [SZ_W-1:0]   push_size,
    input logic              req_accept,
    input logic              req_retry,
    input logic              room_ready,
    input logic              req_done,
    input logic [RO_W-1:0]   rd_occ,
    input logic [WO_W-1:0]   wr_cnt,
    input logic              in_split,
    input logic              in_last
);

    localparam int LOG2B = $clog2(BURST_BYTES);
    localparam logic [ADDR_W-1:0] MASK = ADDR_W'(BURST_BYTES - 1);

    logic piece_act;
    assign piece_act = rd_push || wr_push || fwd_hit || wr_merge;

    AST_PIECE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        piece_act |-> (push_size != '0) && (int'(push_size) <= BURST_BYTES)); // R1
    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        piece_act |-> (int'(push_addr[LOG2B-1:0]) + int'(push_size) <= BURST_BYTES)); // R1
    AST_NEXT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (in_split && !in_last) |=> (push_addr == (($past(push_addr) | MASK) + ADDR_W'(1)))); // R2
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        in_split |-> ($countones({rd_push, wr_push, fwd_hit, wr_merge}) == 1)); // R3
    AST_RD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_occ) <= RD_DEPTH); // R6
    AST_WR_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wr_cnt) <= WR_DEPTH); // R6
    AST_ACC_XOR_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_accept && req_retry)); // R6
    AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_split && in_last) |=> req_done); // R7
    AST_ROOM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        room_ready |=> !room_ready); // R8

endmodule

bind burst_splitter burst_splitter_chk #(
    .ADDR_W     (ADDR_W),
    .BURST_BYTES(BURST_BYTES),
    .RD_DEPTH   (RD_DEPTH),
    .WR_DEPTH   (WR_DEPTH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_push   (rd_push),
    .wr_push   (wr_push),
    .fwd_hit   (fwd_hit),
    .wr_merge  (wr_merge),
    .push_addr (push_addr),
    .push_size (push_size),
    .req_accept(req_accept),
    .req_retry (req_retry),
    .room_ready(room_ready),
    .req_done  (req_done),
    .rd_occ    (rd_occ),
    .wr_cnt    (wr_cnt),
    .in_split  (in_split),
    .in_last   (in_last)
);

// File: tb/burst_splitter_tb_top.sv
`timescale 1ns/1ps
module burst_splitter_tb_top;

    localparam int ADDR_W = 12;
    localparam int LEN_W  = 6;
    localparam int BB     = 8;
    localparam int RDD    = 6;
    localparam int WRD    = 4;
    localparam int SZ_W   = $clog2(BB + 1);
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len_m1 = '0;
    logic              req_accept, req_retry, room_ready;
    logic              rd_pop = 1'b0;
    logic              wr_pop = 1'b0;
    logic              rd_push, wr_push, wr_merge, fwd_hit;
    logic [ADDR_W-1:0] push_addr;
    logic [SZ_W-1:0]   push_size;
    logic [CNT_W-1:0]  fwd_count;
    logic              req_done, done_all_fwd;

    int total = 0;
    int bad   = 0;
    int rd_cnt = 0;
    int wq_a[$];
    int wq_s[$];

    always #4 clk = ~clk;

    burst_splitter #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_BYTES(BB),
        .RD_DEPTH(RDD), .WR_DEPTH(WRD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len_m1(req_len_m1), .req_accept(req_accept),
        .req_retry(req_retry), .room_ready(room_ready), .rd_pop(rd_pop),
        .wr_pop(wr_pop), .rd_push(rd_push), .wr_push(wr_push), .wr_merge(wr_merge),
        .fwd_hit(fwd_hit), .push_addr(push_addr), .push_size(push_size),
        .fwd_count(fwd_count), .req_done(req_done), .done_all_fwd(done_all_fwd)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Issues one request and follows it to completion; returns whether accepted.
    task automatic run_req(input bit w, input int a, input int len, output bit acc);
        int pieces, occ, lim, cur, rem, fwd, sz, edge_b;
        bit cov, bmatch;
        pieces = ((a + len - 1) >> 3) - (a >> 3) + 1;
        occ = w ? wq_a.size() : rd_cnt;
        lim = w ? WRD : RDD;
        acc = (occ + pieces <= lim);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = ADDR_W'(a); req_len_m1 = LEN_W'(len - 1);
        #1;
        chk(req_accept == acc, "R6 accept", int'(req_accept), int'(acc));
        chk(req_retry == !acc, "R6 retry", int'(req_retry), int'(!acc));
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (!acc) return;
        cur = a; rem = len; fwd = 0;
        for (int k = 0; k < pieces; k++) begin
            edge_b = ((cur | (BB - 1)) + 1) - cur;
            sz = (rem < edge_b) ? rem : edge_b;
            chk(push_addr == ADDR_W'(cur), "R2 piece addr", int'(push_addr), cur);
            chk(push_size == SZ_W'(sz), "R1 piece size", int'(push_size), sz);
            chk(req_done == 1'b0, "R7 early done", int'(req_done), 0);
            if (!w) begin
                cov = 1'b0;
                foreach (wq_a[i]) if (wq_a[i] <= cur && cur + sz <= wq_a[i] + wq_s[i]) cov = 1'b1;
                chk(fwd_hit == cov, "R3 fwd_hit", int'(fwd_hit), int'(cov));
                chk(rd_push == !cov, "R3 rd_push", int'(rd_push), int'(!cov));
                if (cov) fwd++; else rd_cnt++;
            end else begin
                bmatch = 1'b0;
                foreach (wq_a[i]) if ((wq_a[i] >> 3) == (cur >> 3)) bmatch = 1'b1;
                chk(wr_merge == bmatch, "R5 wr_merge", int'(wr_merge), int'(bmatch));
                chk(wr_push == !bmatch, "R5 wr_push", int'(wr_push), int'(!bmatch));
                if (!bmatch) begin wq_a.push_back(cur); wq_s.push_back(sz); end
            end
            cur = cur + edge_b; rem = rem - sz;
            @(negedge clk); #1;
        end
        chk(req_done == 1'b1, "R7 done pulse", int'(req_done), 1);
        chk(done_all_fwd == (!w && fwd == pieces), "R4 all fwd", int'(done_all_fwd), int'(!w && fwd == pieces));
        chk(int'(fwd_count) == fwd, "R4 fwd_count", int'(fwd_count), fwd);
        @(negedge clk); #1;
        chk(req_done == 1'b0, "R7 done one cycle", int'(req_done), 0);
    endtask

    task automatic pop_rd();
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
        if (rd_cnt > 0) rd_cnt--;
    endtask

    task automatic pop_wr();
        @(negedge clk); wr_pop = 1'b1;
        @(negedge clk); wr_pop = 1'b0;
        if (wq_a.size() > 0) begin void'(wq_a.pop_front()); void'(wq_s.pop_front()); end
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit acc;
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        chk({req_accept, req_retry, room_ready, rd_push, wr_push, wr_merge, fwd_hit, req_done} == '0,
            "R11 strobes idle", 0, 0);
        chk(fwd_count == '0, "R11 fwd_count", int'(fwd_count), 0);
        rst_n = 1'b1;
        #1;

        // Read sweep: offsets and lengths, empty write queue (R1 R2 R6 R9 R10)
        for (int a = 0; a < 16; a++) begin
            for (int len = 1; len <= 48; len++) begin
                run_req(1'b0, 64 + a, len, acc);
                if (!acc) begin
                    chk(room_ready == 1'b0, "R9 no hold", int'(room_ready), 0);
                    @(negedge clk); #1;
                    chk(room_ready == 1'b0, "R9 no room pulse", int'(room_ready), 0);
                end
                while (rd_cnt > 0) pop_rd();
            end
        end
        // R10: pop on empty read queue changes nothing; a full-depth read still fits
        pop_rd();
        run_req(1'b0, 0, 48, acc);
        chk(acc, "R10 empty pop ignored", int'(acc), 1);
        while (rd_cnt > 0) pop_rd();

        // Write sweep
        for (int a = 0; a < 16; a++) begin
            for (int len = 1; len <= 32; len++) begin
                run_req(1'b1, 128 + a, len, acc);
                if (!acc) begin
                    @(negedge clk); #1;
                    chk(room_ready == 1'b0, "R9 no room pulse wr", int'(room_ready), 0);
                end
                while (wq_a.size() > 0) pop_wr();
            end
        end

        // Forwarding patterns
        run_req(1'b1, 32'h20, 8, acc);          // entry 0x20..0x27
        run_req(1'b0, 32'h22, 4, acc);          // contained: R3 R4 full forward
        run_req(1'b0, 32'h1E, 6, acc);          // first piece not covered, second covered
        run_req(1'b0, 32'h20, 8, acc);          // exact match
        run_req(1'b1, 32'h24, 2, acc);          // R5 merge
        chk(wq_a.size() == 1, "R5 no new entry", wq_a.size(), 1);
        run_req(1'b1, 32'h42, 3, acc);          // entry 0x42..0x44
        run_req(1'b0, 32'h42, 4, acc);          // overlap but not contained: R3
        run_req(1'b0, 32'h43, 2, acc);          // contained
        pop_wr();                               // removes 0x20 entry: R10
        run_req(1'b0, 32'h22, 4, acc);          // no longer forwarded
        chk(rd_cnt > 0, "R10 forward source gone", rd_cnt, 1);
        while (rd_cnt > 0) pop_rd();
        while (wq_a.size() > 0) pop_wr();

        // Hold and room-ready (R8), write side
        run_req(1'b1, 32'h100, 8, acc);
        run_req(1'b1, 32'h108, 8, acc);
        run_req(1'b1, 32'h110, 8, acc);
        run_req(1'b1, 32'h118, 8, acc);
        run_req(1'b1, 32'h1FE, 4, acc);         // needs 2, queue full: refused
        chk(!acc, "R6 refuse full", int'(acc), 0);
        chk(room_ready == 1'b0, "R8 no early room", int'(room_ready), 0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h300; req_len_m1 = '0;
        #1;
        chk(req_accept == 1'b0 && req_retry == 1'b0, "R8 ignore in hold",
            int'(req_accept) + int'(req_retry), 0);
        @(negedge clk); req_valid = 1'b0;
        pop_wr();
        #1;
        chk(room_ready == 1'b0, "R8 one pop not enough", int'(room_ready), 0);
        pop_wr();
        #1;
        chk(room_ready == 1'b1, "R8 room pulse", int'(room_ready), 1);
        @(negedge clk); #1;
        chk(room_ready == 1'b0, "R8 pulse one cycle", int'(room_ready), 0);
        run_req(1'b1, 32'h114, 1, acc);         // merges into 0x110 entry
        chk(acc && wq_a.size() == 2, "R5 merge after hold", wq_a.size(), 2);
        run_req(1'b1, 32'h120, 16, acc);        // fills to 4
        run_req(1'b1, 32'h11C, 1, acc);         // would merge but still refused
        chk(!acc, "R6 merge still needs room", int'(acc), 0);
        pop_wr();
        #1;
        chk(room_ready == 1'b1, "R8 room after pop", int'(room_ready), 1);
        @(negedge clk);
        while (wq_a.size() > 0) pop_wr();

        // Read-side hold
        run_req(1'b0, 0, 40, acc);              // 5 entries
        run_req(1'b0, 32'h80, 9, acc);          // needs 2: refused
        chk(!acc, "R6 read refuse", int'(acc), 0);
        pop_rd();
        #1;
        chk(room_ready == 1'b1, "R8 read room", int'(room_ready), 1);
        @(negedge clk);
        while (rd_cnt > 0) pop_rd();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule